// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block makes the repeated-start condition for an I2C master. It drives open-drain SCL and SDA through two pull-low enables and reads both lines back. Software writes a request bit in an 8-bit command register. The block then walks the bus through a fixed order. It pulls SCL low and lets SDA float high. Next it releases SCL and holds both lines high. Last, it pulls SDA low while SCL stays high. Each step is timed by a 7-bit baud-rate down-counter. No step begins until the line levels read back confirm the previous step. This lets a slave stretch the clock, or another master hold the bus, without breaking the timing.

Only one event can be in progress at a time. The request bit clears itself when the sequence ends. While the sequence runs, the block refuses two kinds of write: transmit-buffer writes (these raise a write-collision flag) and changes to the low command bits. Four sticky flags report the result: start seen, sequence complete, write collision and bus collision. Software clears each flag by writing a zero to it.

Top module: `i2c_rstart_seq`

## Requirements
- R1: After reset, both pull-low enables, all four flags, the command register and the transmit buffer read zero.
- R2: Command bit 1 is the repeated-start request. It is accepted only when the sequencer is idle and `evt_busy` is low. If `evt_busy` is high, the other bits are stored, bit 1 reads back zero and SCL is not pulled.
- R3: In the cycle after an accepted request, SCL is pulled low and SDA is released. The counter is loaded with the reload value R only after SCL is seen low through the 2-flop synchronizer. With no stretching, SCL is released R+4 cycles after the accepting clock edge.
- R4: When the first count expires, SCL is released only once SDA is seen high. If SDA is held low until D cycles after that expiry, SCL is released R+7+D cycles after acceptance.
- R5: After the synchronized SCL is seen high, the counter is reloaded. SDA is pulled low R+4 cycles after SCL was released. Any time the bus holds SCL low after release adds to this delay cycle for cycle.
- R6: SDA stays pulled low for R+1 cycles. Then the request bit clears and the complete flag (flag bit 1) sets. SDA then stays pulled low and SCL stays released.
- R7: The start flag (flag bit 0) sets when the synchronized SDA falls while the synchronized SCL is high.
- R8: A transmit-buffer write during a sequence leaves the buffer unchanged and sets the write-collision flag (flag bit 2). When the block is idle, the write updates the buffer.
- R9: During a sequence, command writes leave bits 4..0 unchanged, and bits 7..5 take the written value.
- R10: If SDA is seen low when the synchronized SCL rises, the block signals a bus collision. It sets flag bit 3, releases both lines, clears the request bit and returns to idle without setting the complete flag.
- R11: In either high phase, a bus collision is signalled if SCL is seen low before SDA is seen low. The response is the same as in R10.
- R12: All flags are sticky. A flag write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_busy | input | 1 | Another master event is in progress |
| ctl_wr | input | 1 | Command register write strobe |
| ctl_wdata | input | 8 | Command write data, bit 1 = request |
| ctl_rd | output | 8 | Command register contents |
| brg_reload | input | 7 | Baud-rate counter reload value R |
| txb_wr | input | 1 | Transmit buffer write strobe |
| txb_wdata | input | 8 | Transmit buffer write data |
| txb_q | output | 8 | Transmit buffer contents |
| flag_wr | input | 1 | Flag clear strobe |
| flag_wdata | input | 4 | Flag mask: {bcol, wcol, done, start}, 0 clears |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| start_det | output | 1 | Start condition seen |
| done_irq | output | 1 | Sequence complete |
| wcol | output | 1 | Write collision |
| bcol | output | 1 | Bus collision |

## Verification
The assertions assume the following about the bus:

- The line levels follow the pull enables. They can only be pulled lower by another agent.
- `brg_reload` does not change while a sequence runs.
- `flag_wr` never happens in the same cycle as a flag set.

The bench models the bus as a wired-AND of the design's pulls and the bench's own holds. It changes the reload value only between sequences. It clears flags only while the design is idle. Random reload values, SDA hold delays and SCL stretch lengths are drawn inside those limits.

// File: rtl/i2c_rs_pkg.sv
// Package: shared types for the repeated-start sequencer.
// Assumes: nothing beyond standard SystemVerilog packed types.
package i2c_rs_pkg;

    // Sequencer phases, in bus order
    typedef enum logic [2:0] {
        RS_IDLE     = 3'd0,
        RS_SCL_DN   = 3'd1,
        RS_SDA_REL  = 3'd2,
        RS_SDA_WAIT = 3'd3,
        RS_SCL_UP   = 3'd4,
        RS_HOLD_HI  = 3'd5,
        RS_SDA_DN   = 3'd6
    } rs_state_e;

    localparam int FLAG_W     = 4;
    localparam int FLAG_START = 0;
    localparam int FLAG_DONE  = 1;
    localparam int FLAG_WCOL  = 2;
    localparam int FLAG_BCOL  = 3;

endpackage

// File: rtl/i2c_rs_sync.sv
// Module: multi-line synchronizer chain.
// Does: passes each asynchronous line level through STAGES flops.
// Assumes: lines idle high, so reset fills the chain with ones.
module i2c_rs_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_in,
    output logic [LINES-1:0] sync_out
);

    logic [STAGES-1:0][LINES-1:0] chain_q;

    // shift the raw levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= raw_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/i2c_rs_brg.sv
// Module: baud-rate down-counter.
// Does: loads the reload value on load, decrements while run is high, stops at zero.
// Assumes: load wins over run; zero flags the end of a period.
module i2c_rs_brg #(
    parameter int BRG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [BRG_W-1:0] reload,
    output logic             zero
);

    logic [BRG_W-1:0] cnt_q;

    // count down one step per cycle, or reload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/i2c_rs_fsm.sv
// Module: repeated-start phase sequencer.
// Does: steps SCL low, SDA high, both high, SDA low, gating each step on
//       synchronized line levels and the baud-rate period; detects collisions.
// Assumes: scl_s/sda_s are already synchronized; go only pulses while idle.
module i2c_rs_fsm
    import i2c_rs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic scl_s,
    input  logic sda_s,
    input  logic brg_zero,
    output logic brg_load,
    output logic brg_run,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy,
    output logic seq_done,
    output logic seq_coll
);

    rs_state_e state_q, state_d;
    logic      hold_sda_q;

    // next-phase and counter control decode
    always_comb begin
        state_d  = state_q;
        brg_load = 1'b0;
        brg_run  = 1'b0;
        seq_done = 1'b0;
        seq_coll = 1'b0;
        unique case (state_q)
            RS_IDLE: begin
                if (go) state_d = RS_SCL_DN;
            end
            RS_SCL_DN: begin
                brg_load = 1'b1;
                if (!scl_s) state_d = RS_SDA_REL;
            end
            RS_SDA_REL: begin
                brg_run = 1'b1;
                if (brg_zero) state_d = sda_s ? RS_SCL_UP : RS_SDA_WAIT;
            end
            RS_SDA_WAIT: begin
                brg_load = 1'b1;
                if (sda_s) state_d = RS_SCL_UP;
            end
            RS_SCL_UP: begin
                brg_load = 1'b1;
                if (scl_s) begin
                    if (!sda_s) begin
                        seq_coll = 1'b1;
                        state_d  = RS_IDLE;
                    end else begin
                        state_d = RS_HOLD_HI;
                    end
                end
            end
            RS_HOLD_HI: begin
                brg_run = 1'b1;
                if (!scl_s) begin
                    seq_coll = 1'b1;
                    state_d  = RS_IDLE;
                end else if (brg_zero) begin
                    brg_load = 1'b1;
                    state_d  = RS_SDA_DN;
                end
            end
            RS_SDA_DN: begin
                brg_run = 1'b1;
                if (!scl_s && sda_s) begin
                    seq_coll = 1'b1;
                    state_d  = RS_IDLE;
                end else if (brg_zero) begin
                    seq_done = 1'b1;
                    state_d  = RS_IDLE;
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // phase register and the SDA hold left after completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RS_IDLE;
            hold_sda_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (seq_done) begin
                hold_sda_q <= 1'b1;
            end else if (go || seq_coll) begin
                hold_sda_q <= 1'b0;
            end
        end
    end

    // line drive follows the phase
    always_comb begin
        scl_pull = (state_q == RS_SCL_DN) || (state_q == RS_SDA_REL) ||
                   (state_q == RS_SDA_WAIT);
        sda_pull = (state_q == RS_SDA_DN) ||
                   ((state_q == RS_IDLE) && hold_sda_q);
    end

    assign busy = (state_q != RS_IDLE);

endmodule

// File: rtl/i2c_rstart_seq.sv
// Module: I2C master repeated-start sequencer (top).
// Does: holds the command register, transmit buffer and sticky flags; runs
//       the sequencer on synchronized bus levels; blocks writes while busy.
// Assumes: open-drain lines with external pull-ups; reload value stable
//          during a sequence.
module i2c_rstart_seq
    import i2c_rs_pkg::*;
#(
    parameter int CTL_W       = 8,
    parameter int CMD_W       = 5,
    parameter int REQ_BIT     = 1,
    parameter int BRG_W       = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_busy,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rd,
    input  logic [BRG_W-1:0]  brg_reload,
    input  logic              txb_wr,
    input  logic [DATA_W-1:0] txb_wdata,
    output logic [DATA_W-1:0] txb_q,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_wdata,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              start_det,
    output logic              done_irq,
    output logic              wcol,
    output logic              bcol
);

    localparam int SYNC_LINES = 2;

    logic [SYNC_LINES-1:0] line_s;
    logic                  scl_s, sda_s, sda_prev_q;
    logic                  brg_load, brg_run, brg_zero;
    logic                  seq_busy, seq_done, seq_coll, seq_end;
    logic                  accept;
    logic [CTL_W-1:0]      ctl_q;
    logic [DATA_W-1:0]     txb_buf_q;
    logic [FLAG_W-1:0]     flag_q, flag_set, flag_keep, flag_nxt;

    i2c_rs_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (SYNC_LINES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({sda_in, scl_in}),
        .sync_out (line_s)
    );

    assign scl_s = line_s[0];
    assign sda_s = line_s[1];

    i2c_rs_brg #(
        .BRG_W (BRG_W)
    ) brg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (brg_load),
        .run    (brg_run),
        .reload (brg_reload),
        .zero   (brg_zero)
    );

    i2c_rs_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (accept),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .brg_zero (brg_zero),
        .brg_load (brg_load),
        .brg_run  (brg_run),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy     (seq_busy),
        .seq_done (seq_done),
        .seq_coll (seq_coll)
    );

    assign accept  = ctl_wr && ctl_wdata[REQ_BIT] && !seq_busy && !evt_busy;
    assign seq_end = seq_done || seq_coll;

    // command register: low bits locked while busy, request self-clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q[CTL_W-1:CMD_W] <= ctl_wdata[CTL_W-1:CMD_W];
                if (!seq_busy) begin
                    ctl_q[CMD_W-1:0] <= ctl_wdata[CMD_W-1:0];
                    ctl_q[REQ_BIT]   <= accept;
                end
            end
            if (seq_end) begin
                ctl_q[REQ_BIT] <= 1'b0;
            end
        end
    end

    // transmit buffer: written only while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txb_buf_q <= '0;
        end else if (txb_wr && !seq_busy) begin
            txb_buf_q <= txb_wdata;
        end
    end

    // previous synchronized SDA level for start detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_prev_q <= 1'b1;
        end else begin
            sda_prev_q <= sda_s;
        end
    end

    // flag set sources
    always_comb begin
        flag_set             = '0;
        flag_set[FLAG_START] = scl_s && sda_prev_q && !sda_s;
        flag_set[FLAG_DONE]  = seq_done;
        flag_set[FLAG_WCOL]  = txb_wr && seq_busy;
        flag_set[FLAG_BCOL]  = seq_coll;
    end

    // per-flag keep/set merge
    for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
        assign flag_keep[f] = flag_wr ? flag_wdata[f] : 1'b1;
        assign flag_nxt[f]  = (flag_q[f] && flag_keep[f]) || flag_set[f];
    end

    // sticky flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_nxt;
        end
    end

    assign ctl_rd    = ctl_q;
    assign txb_q     = txb_buf_q;
    assign start_det = flag_q[FLAG_START];
    assign done_irq  = flag_q[FLAG_DONE];
    assign wcol      = flag_q[FLAG_WCOL];
    assign bcol      = flag_q[FLAG_BCOL];

endmodule

// File: rtl/i2c_rstart_seq_chk.sv
// Module: property checker for the repeated-start sequencer.
// Does: checks launch, completion, collision, write-lock and flag rules.
// Assumes: flag clears never coincide with a flag set.
module i2c_rstart_seq_chk #(
    parameter int CTL_W   = 8,
    parameter int CMD_W   = 5,
    parameter int REQ_BIT = 1,
    parameter int DATA_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_busy,
    input logic              ctl_wr,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [CTL_W-1:0]  ctl_rd,
    input logic              txb_wr,
    input logic [DATA_W-1:0] txb_q,
    input logic              flag_wr,
    input logic              scl_pull,
    input logic              sda_pull,
    input logic              done_irq,
    input logic              wcol,
    input logic              bcol,
    input logic              seq_busy,
    input logic              seq_end
);

    // R3
    req_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rd[REQ_BIT]) |-> scl_pull && !sda_pull);

    // R2
    ignored_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[REQ_BIT] && evt_busy && !seq_busy)
        |=> !ctl_rd[REQ_BIT] && !scl_pull);

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_irq) |-> sda_pull && !scl_pull && !ctl_rd[REQ_BIT]);

    // R10
    coll_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bcol) |-> !scl_pull && !sda_pull && !seq_busy && !ctl_rd[REQ_BIT]);

    // R8
    buf_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txb_wr && seq_busy) |=> $stable(txb_q) && wcol);

    // R9
    cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && seq_busy && !seq_end)
        |=> ctl_rd[CMD_W-1:0] == $past(ctl_rd[CMD_W-1:0]));

    // R12
    sticky_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq && !flag_wr) |=> done_irq);

endmodule

bind i2c_rstart_seq i2c_rstart_seq_chk #(
    .CTL_W   (CTL_W),
    .CMD_W   (CMD_W),
    .REQ_BIT (REQ_BIT),
    .DATA_W  (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_busy  (evt_busy),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rd    (ctl_rd),
    .txb_wr    (txb_wr),
    .txb_q     (txb_q),
    .flag_wr   (flag_wr),
    .scl_pull  (scl_pull),
    .sda_pull  (sda_pull),
    .done_irq  (done_irq),
    .wcol      (wcol),
    .bcol      (bcol),
    .seq_busy  (seq_busy),
    .seq_end   (seq_end)
);

// File: tb/i2c_rstart_seq_tb_top.sv
// Bench: wired-AND bus model, directed corners plus seeded random timing runs.
module i2c_rstart_seq_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_busy = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rd;
    logic [6:0] brg_reload = 7'd4;
    logic       txb_wr = 1'b0;
    logic [7:0] txb_wdata = '0;
    logic [7:0] txb_q;
    logic       flag_wr = 1'b0;
    logic [3:0] flag_wdata = '0;
    logic       scl_pull, sda_pull, start_det, done_irq, wcol, bcol;
    logic       tb_scl_lo = 1'b0;
    logic       tb_sda_lo = 1'b0;
    logic       scl_ln, sda_ln;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    assign scl_ln = !(scl_pull || tb_scl_lo);
    assign sda_ln = !(sda_pull || tb_sda_lo);

    i2c_rstart_seq dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_busy   (evt_busy),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rd     (ctl_rd),
        .brg_reload (brg_reload),
        .txb_wr     (txb_wr),
        .txb_wdata  (txb_wdata),
        .txb_q      (txb_q),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .scl_in     (scl_ln),
        .sda_in     (sda_ln),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .start_det  (start_det),
        .done_irq   (done_irq),
        .wcol       (wcol),
        .bcol       (bcol)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    // expected cycle of SCL release after the accepting edge (R3, R4)
    function automatic int exp_rel(input int r, input bit sda_hold, input int d);
        return r + 4 + (sda_hold ? 3 + d : 0);
    endfunction

    // expected cycle SDA is pulled (R5)
    function automatic int exp_sda(input int r, input int rel, input int h);
        return rel + h + r + 4;
    endfunction

    task automatic clear_flags();
        flag_wdata = 4'b0000;
        flag_wr    = 1'b1;
        step();
        flag_wr    = 1'b0;
    endtask

    task automatic ctl_write(input logic [7:0] w);
        ctl_wdata = w;
        ctl_wr    = 1'b1;
        step();
        ctl_wr    = 1'b0;
        cyc       = 0;
    endtask

    task automatic wait_done(input int limit);
        for (int k = 0; k < limit; k++) begin
            if (done_irq || bcol) break;
            step();
        end
    endtask

    // full timed sequence with optional SDA hold and SCL stretch
    task automatic timed_seq(input int r, input bit sda_hold, input int d, input int h);
        int t_rel, t_sda, t_done, e_rel, e_sda;
        t_rel = -1; t_sda = -1; t_done = -1;
        e_rel = exp_rel(r, sda_hold, d);
        e_sda = exp_sda(r, e_rel, h);
        brg_reload = 7'(r);
        clear_flags();
        tb_sda_lo = sda_hold;
        ctl_write(8'h02);
        for (int n = 0; n < 600; n++) begin
            if (n > 0) step();
            if (n == 0) begin
                // R3 launch: SCL pulled, SDA released
                check(scl_pull && !sda_pull, "R3", {scl_pull, sda_pull}, 2);
            end
            if (!scl_pull && t_rel < 0) t_rel = n;
            if (sda_pull && t_sda < 0) t_sda = n;
            if (done_irq && t_done < 0) t_done = n;
            tb_sda_lo = sda_hold && (n < r + 4 + d);
            tb_scl_lo = (n < e_rel + h);
            if (t_done >= 0) break;
        end
        tb_scl_lo = 1'b0;
        tb_sda_lo = 1'b0;
        check(t_rel == e_rel, sda_hold ? "R4" : "R3", t_rel, e_rel);
        check(t_sda == e_sda, "R5", t_sda, e_sda);
        check(t_done == e_sda + r + 1, "R6", t_done, e_sda + r + 1);
        check(ctl_rd[1] == 1'b0 && sda_pull && !scl_pull, "R6", {ctl_rd[1], sda_pull, scl_pull}, 2);
        repeat (4) step();
        check(start_det == 1'b1, "R7", start_det, 1);
        check(bcol == 1'b0, "R10", bcol, 0);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(!scl_pull && !sda_pull, "R1", {scl_pull, sda_pull}, 0);
        check({bcol, wcol, done_irq, start_det} == 4'b0, "R1", {bcol, wcol, done_irq, start_det}, 0);
        check(ctl_rd == 8'h00 && txb_q == 8'h00, "R1", ctl_rd, 0);

        // R2 request refused while another event is busy
        evt_busy = 1'b1;
        ctl_write(8'h0A);
        step(); step();
        check(ctl_rd == 8'h08, "R2", ctl_rd, 8'h08);
        check(!scl_pull, "R2", scl_pull, 0);
        evt_busy = 1'b0;
        ctl_write(8'h00);

        // R8 idle buffer write is accepted
        txb_wdata = 8'h5A; txb_wr = 1'b1; step(); txb_wr = 1'b0;
        check(txb_q == 8'h5A && !wcol, "R8", txb_q, 8'h5A);

        // directed plain sequence and SDA-hold corner
        timed_seq(5, 1'b0, 0, 0);
        timed_seq(0, 1'b0, 0, 0);
        timed_seq(3, 1'b1, 5, 0);

        // R12 selective clear, then full clear
        flag_wdata = 4'b1101; flag_wr = 1'b1; step(); flag_wr = 1'b0;
        check(!done_irq && start_det, "R12", {done_irq, start_det}, 1);
        step();
        check(start_det, "R12", start_det, 1);
        clear_flags();
        check({bcol, wcol, done_irq, start_det} == 4'b0, "R12", {bcol, wcol, done_irq, start_det}, 0);

        // R8 / R9 writes during a sequence
        brg_reload = 7'd15;
        ctl_write(8'h06);
        repeat (5) step();
        txb_wdata = 8'hA5; txb_wr = 1'b1; step(); txb_wr = 1'b0;
        check(wcol && txb_q == 8'h5A, "R8", txb_q, 8'h5A);
        ctl_wdata = 8'hF9; ctl_wr = 1'b1; step(); ctl_wr = 1'b0;
        check(ctl_rd == 8'hE6, "R9", ctl_rd, 8'hE6);
        wait_done(300);
        check(done_irq && ctl_rd == 8'hE4, "R9", ctl_rd, 8'hE4);
        ctl_write(8'h00);

        // R10 SDA low as SCL rises
        brg_reload = 7'd6;
        clear_flags();
        ctl_write(8'h02);
        while (cyc < 6 + 4) step();
        tb_sda_lo = 1'b1;
        while (cyc < 6 + 8) step();
        check(bcol && !scl_pull && !sda_pull, "R10", {bcol, scl_pull, sda_pull}, 4);
        check(ctl_rd[1] == 1'b0, "R10", ctl_rd[1], 0);
        tb_sda_lo = 1'b0;
        repeat (40) step();
        check(!done_irq, "R10", done_irq, 0);

        // R11 SCL dropped during the both-high period
        brg_reload = 7'd10;
        clear_flags();
        ctl_write(8'h02);
        while (cyc < 10 + 8) step();
        tb_scl_lo = 1'b1;
        while (cyc < 10 + 13) step();
        check(bcol && !scl_pull && !sda_pull, "R11", {bcol, scl_pull, sda_pull}, 4);
        tb_scl_lo = 1'b0;
        repeat (50) step();
        check(!done_irq && ctl_rd[1] == 1'b0, "R11", done_irq, 0);

        // random timing runs
        for (int it = 0; it < 14; it++) begin
            int r, d, h;
            bit m;
            r = $urandom_range(0, 12);
            m = 1'($urandom_range(0, 1));
            d = $urandom_range(0, 4);
            h = $urandom_range(0, 4);
            timed_seq(r, m, d, h);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule